// File: doc/BRIEF.md
# ADC conversion clock and timing tick divider

This block turns the system clock into a one-cycle conversion clock enable for an analog-to-digital converter. From that enable it also derives two slower tick pulses: one nominally every 10 microseconds and one nominally every millisecond. Software loads one 32-bit divider word that holds three divide fields. Each field stores its ratio minus one. Software computes the field values from the clock frequencies. The main ratio is chosen so that the divided conversion rate lands between 20 kHz and 200 kHz.

The two tick stages count conversion clock enables, not system clocks. Their periods are therefore products of the main ratio and their own ratio. Loading the divider word restarts all three stages from zero, so software gets a known phase after every write.

Top module: `adc_clkdiv`

## Requirements
- R1: After reset all three fields are zero. Until the first write, `adc_clk_en_o`, `tick_10us_o` and `tick_ms_o` are all high in every system clock cycle.
- R2: The divider word splits into three fields: bits [7:0] give the main ratio M+1, bits [15:8] give the 10 us ratio U+1, and bits [31:16] give the millisecond ratio S+1. A field value of 0 means divide by 1, and a main ratio of 256 and a millisecond ratio of 65536 are reachable.
- R3: `adc_clk_en_o` is high for one system clock in every M+1 system clocks. Its first pulse comes in the (M+1)-th cycle after the write edge.
- R4: `tick_10us_o` is high only in cycles where `adc_clk_en_o` is high. It is high on every (U+1)-th conversion enable counted from the write, so it is one system clock wide.
- R5: `tick_ms_o` is high only in cycles where `adc_clk_en_o` is high. It is high on every (S+1)-th conversion enable counted from the write, independently of U.
- R6: In a cycle with `wr_en_i` high, no output pulses. At that clock edge all three counters restart from zero, whatever phase they had reached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Load the divider word this cycle |
| wr_data_i | input | 32 | Divider word: {ms field, 10 us field, main field} |
| adc_clk_en_o | output | 1 | Conversion clock enable, one system clock wide |
| tick_10us_o | output | 1 | 10 us tick, one system clock wide |
| tick_ms_o | output | 1 | Millisecond tick, one system clock wide |

## Verification
On every cycle, the checker confirms three things:
- The spacing between conversion enables is exactly the main ratio, and no pulse comes late.
- Each tick falls on a conversion enable and after exactly its own count of enables.
- A write cycle is quiet.

Only the bench scenarios can show the rest:
- The fields are decoded at the right bit positions.
- The absolute first-pulse cycle after a write is right.
- The reset default is correct.
- Counting restarts from zero when a write lands mid-phase, including at the largest main and millisecond ratios.

// File: rtl/adc_clkdiv_pkg.sv
package adc_clkdiv_pkg;
  localparam int unsigned MAIN_W_DEF = 8;
  localparam int unsigned US_W_DEF   = 8;
  localparam int unsigned MS_W_DEF   = 16;
endpackage

// File: rtl/adc_div_cfg_reg.sv
module adc_div_cfg_reg #(
  parameter int unsigned MAIN_W = 8,
  parameter int unsigned US_W   = 8,
  parameter int unsigned MS_W   = 16,
  localparam int unsigned REG_W = MAIN_W + US_W + MS_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [REG_W-1:0]  wr_data_i,
  output logic [MAIN_W-1:0] main_lim_o,
  output logic [US_W-1:0]   us_lim_o,
  output logic [MS_W-1:0]   ms_lim_o,
  output logic              clr_o
);
  localparam int unsigned US_LSB = MAIN_W;
  localparam int unsigned MS_LSB = MAIN_W + US_W;

  logic [REG_W-1:0] cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cfg_q <= '0;
    else if (wr_en_i) cfg_q <= wr_data_i;
  end

  assign main_lim_o = cfg_q[MAIN_W-1:0];
  assign us_lim_o   = cfg_q[US_LSB +: US_W];
  assign ms_lim_o   = cfg_q[MS_LSB +: MS_W];
  // counters restart on the same edge that loads the new fields
  assign clr_o      = wr_en_i;
endmodule

// File: rtl/adc_div_stage.sv
module adc_div_stage #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             step_i,
  input  logic [CNT_W-1:0] lim_i,
  output logic             hit_o
);
  logic [CNT_W-1:0] cnt_q;

  assign hit_o = step_i & ~clr_i & (cnt_q == lim_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (step_i) cnt_q <= hit_o ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/adc_clkdiv.sv
module adc_clkdiv
  import adc_clkdiv_pkg::*;
#(
  parameter int unsigned MAIN_W = MAIN_W_DEF,
  parameter int unsigned US_W   = US_W_DEF,
  parameter int unsigned MS_W   = MS_W_DEF,
  localparam int unsigned REG_W = MAIN_W + US_W + MS_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic             adc_clk_en_o,
  output logic             tick_10us_o,
  output logic             tick_ms_o
);
  logic [MAIN_W-1:0] main_lim;
  logic [US_W-1:0]   us_lim;
  logic [MS_W-1:0]   ms_lim;
  logic              clr;
  logic              adc_en;

  adc_div_cfg_reg #(.MAIN_W(MAIN_W), .US_W(US_W), .MS_W(MS_W)) u_cfg (
    .clk_i, .rst_ni, .wr_en_i, .wr_data_i,
    .main_lim_o(main_lim), .us_lim_o(us_lim), .ms_lim_o(ms_lim), .clr_o(clr)
  );

  adc_div_stage #(.CNT_W(MAIN_W)) u_main (
    .clk_i, .rst_ni, .clr_i(clr), .step_i(1'b1), .lim_i(main_lim), .hit_o(adc_en)
  );

  // slow stages advance only on conversion enables
  adc_div_stage #(.CNT_W(US_W)) u_us (
    .clk_i, .rst_ni, .clr_i(clr), .step_i(adc_en), .lim_i(us_lim), .hit_o(tick_10us_o)
  );

  adc_div_stage #(.CNT_W(MS_W)) u_ms (
    .clk_i, .rst_ni, .clr_i(clr), .step_i(adc_en), .lim_i(ms_lim), .hit_o(tick_ms_o)
  );

  assign adc_clk_en_o = adc_en;
endmodule

// File: rtl/adc_clkdiv_chk.sv
module adc_clkdiv_chk #(
  parameter int unsigned MAIN_W = 8,
  parameter int unsigned US_W   = 8,
  parameter int unsigned MS_W   = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic              adc_clk_en_o,
  input logic              tick_10us_o,
  input logic              tick_ms_o,
  input logic [MAIN_W-1:0] main_lim,
  input logic [US_W-1:0]   us_lim,
  input logic [MS_W-1:0]   ms_lim
);
  logic [MAIN_W:0] gap_q;
  logic [US_W:0]   us_n_q;
  logic [MS_W:0]   ms_n_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q <= '0; us_n_q <= '0; ms_n_q <= '0;
    end else if (wr_en_i) begin
      gap_q <= '0; us_n_q <= '0; ms_n_q <= '0;
    end else begin
      gap_q <= adc_clk_en_o ? '0 : gap_q + 1'b1;
      if (adc_clk_en_o) begin
        us_n_q <= tick_10us_o ? '0 : us_n_q + 1'b1;
        ms_n_q <= tick_ms_o   ? '0 : ms_n_q + 1'b1;
      end
    end
  end

  AST_ADC_PERIOD:   assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_clk_en_o |-> gap_q == {1'b0, main_lim});                        // R3
  AST_ADC_NOT_LATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |-> gap_q <= {1'b0, main_lim});                            // R3
  AST_US_ON_ADC:    assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_10us_o |-> adc_clk_en_o);                                      // R4
  AST_US_COUNT:     assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_10us_o |-> us_n_q == {1'b0, us_lim});                          // R4
  AST_US_NOT_LATE:  assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adc_clk_en_o && !tick_10us_o) |-> us_n_q < {1'b0, us_lim});        // R4
  AST_MS_ON_ADC:    assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_ms_o |-> adc_clk_en_o);                                        // R5
  AST_MS_COUNT:     assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_ms_o |-> ms_n_q == {1'b0, ms_lim});                            // R5
  AST_MS_NOT_LATE:  assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adc_clk_en_o && !tick_ms_o) |-> ms_n_q < {1'b0, ms_lim});          // R5
  AST_WR_QUIET:     assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> !(adc_clk_en_o || tick_10us_o || tick_ms_o));           // R6
endmodule

bind adc_clkdiv adc_clkdiv_chk #(.MAIN_W(MAIN_W), .US_W(US_W), .MS_W(MS_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i),
  .adc_clk_en_o(adc_clk_en_o), .tick_10us_o(tick_10us_o), .tick_ms_o(tick_ms_o),
  .main_lim(main_lim), .us_lim(us_lim), .ms_lim(ms_lim)
);

// File: tb/adc_clkdiv_bench.sv
`timescale 1ns/1ps
module adc_clkdiv_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        adc_o, us_o, ms_o;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit sb_on = 1'b0;
  bit done  = 1'b0;
  int q_adc[$];
  int q_us[$];
  int q_ms[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  adc_clkdiv u_adc_clkdiv (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .adc_clk_en_o(adc_o), .tick_10us_o(us_o), .tick_ms_o(ms_o)
  );

  task automatic chk(input bit act, input bit exp, input string req, input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s cycle=%0d actual=%0b expected=%0b", req, what, cyc, act, exp);
    end
  endtask

  // scoreboard monitor: samples mid-interval
  always @(negedge clk) begin
    #5;
    if (sb_on) begin
      bit e;
      e = (q_adc.size() > 0 && q_adc[0] == cyc);
      if (e) void'(q_adc.pop_front());
      chk(adc_o, e, wr_en ? "R6" : "R3", "adc_clk_en_o");
      e = (q_us.size() > 0 && q_us[0] == cyc);
      if (e) void'(q_us.pop_front());
      chk(us_o, e, wr_en ? "R6" : "R4", "tick_10us_o");
      e = (q_ms.size() > 0 && q_ms[0] == cyc);
      if (e) void'(q_ms.pop_front());
      chk(ms_o, e, wr_en ? "R6" : "R5", "tick_ms_o");
    end
  end

  // driver: called at a falling edge; writes, predicts, runs w cycles
  task automatic configure(input int m, input int u, input int s, input int w);
    logic [7:0]  mf = m[7:0];
    logic [7:0]  uf = u[7:0];
    logic [15:0] sf = s[15:0];
    int cw;
    wr_data = {sf, uf, mf};
    wr_en   = 1'b1;
    cw      = cyc + 1;
    for (int n = 1; ; n++) begin
      int t = cw + n * (m + 1) - 1;
      if (t >= cw + w) break;
      q_adc.push_back(t);
      if (n % (u + 1) == 0) q_us.push_back(t);
      if (n % (s + 1) == 0) q_ms.push_back(t);
    end
    sb_on = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    repeat (w) @(negedge clk);
    chk(q_adc.size() == 0, 1'b1, "R2", "adc queue drained");
    chk(q_us.size()  == 0, 1'b1, "R2", "10us queue drained");
    chk(q_ms.size()  == 0, 1'b1, "R2", "ms queue drained");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 5; i++) begin
      #5;
      chk(adc_o, 1'b1, "R1", "adc_clk_en_o after reset");
      chk(us_o,  1'b1, "R1", "tick_10us_o after reset");
      chk(ms_o,  1'b1, "R1", "tick_ms_o after reset");
      @(negedge clk);
    end
    configure(3, 4, 9, 400);
    configure(255, 0, 0, 2000);
    configure(0, 255, 1, 1200);
    configure(0, 0, 1000, 3100);
    configure(1, 2, 3, 97);     // leaves counters mid-phase
    configure(9, 9, 2, 1500);   // restart from arbitrary phase
    configure(0, 0, 0, 50);
    configure(0, 0, 65535, 65540);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog cycle=%0d actual=running expected=finished", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule